// File: doc/BRIEF.md
# Multi-Mode Pixel Output Packer

The packer accepts 24-bit RGB pixels over a ready/valid handshake (red in bits 23:16, green in 15:8, blue in 7:0). On each cycle where the shift-clock enable is high, it drives one word onto an 18-bit panel data bus. Four output formats are available. Two are one-pixel-per-clock formats: 16-bit 565 and 15-bit 555. The third packs three one-bit components per pixel onto an 8-bit bus, so eight pixels take three clocks and pixels are split across clock boundaries. The fourth packs four pixels per clock from component MSBs.

Each accepted pixel is turned into a mode-specific code. The code is appended to a 32-bit bit buffer directly above the residue already held. A shift pulse removes one output word from the bottom of the buffer when the buffer holds enough bits for it. Otherwise the pulse yields an empty word. Frame buffer fetch and display timing belong to neighbouring blocks, which supply the pixels and the shift-clock enable.

Top module: `pix_out_packer`

## Requirements
- R1: Mode 0 (565): each word carries one pixel, with blue[7:3] in data bits 4:0, green[7:2] in bits 10:5 and red[7:3] in bits 15:11.
- R2: Mode 1 (555): each word carries one pixel, with blue[7:3] in bits 4:0, green[7:3] in bits 9:5 and red[7:3] in bits 14:10.
- R3: Mode 2 (eight pixels in three clocks): pixel k contributes three bits to a continuous bit stream. Blue[7] goes to stream bit 3k, green[7] to 3k+1 and red[7] to 3k+2. Word c carries stream bits 8c to 8c+7 on data bits 7:0.
- R4: In mode 2, the red MSB of the third pixel of a group (pixel 2) appears on bit 0 of the second word. The sixth pixel (pixel 5) places its green MSB on bit 0 and its red MSB on bit 1 of the third word.
- R5: Mode 3 (four pixels per clock): pixel j of a word occupies bits 4j to 4j+3 as blue[7], green[7], red[7], red[6]. Only the MSB of green and of blue is output.
- R6: Data bits not used by the current mode are driven to zero.
- R7: A shift-enable pulse produces data_valid_o high and the next word one cycle later. If fewer bits are buffered than one word needs, the word is zero and data_valid_o stays low. Without a shift-enable, data_valid_o is low.
- R8: pix_ready_o is high only while the buffer has room for one more pixel code. It falls after two pixels in mode 0 and after ten pixels in mode 2 with no shifts. No accepted pixel is lost or reordered.
- R9: After reset, pix_ready_o is high, data_valid_o is low and data_o is zero.
- R10: mode_i changes only while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Output format select (0..3) |
| pix_i | input | 24 | RGB pixel, red in the top byte |
| pix_valid_i | input | 1 | Pixel offered |
| pix_ready_o | output | 1 | Packer can accept a pixel |
| shift_en_i | input | 1 | Shift-clock enable, one word per pulse |
| data_o | output | 18 | Panel data bus |
| data_valid_o | output | 1 | data_o carries a fresh word |

## Verification
A wrong residue count or shift amount in mode 2 shows at the ports within one group of eight pixels. The second or third word of the group then has its split pixel on the wrong bits. Every later word in the run is misaligned too. A miscomputed buffer fill shows either as pix_ready_o failing to fall after the second 565 pixel, or as a valid word when the buffer is empty. Both appear in the cycle after the stimulus that causes them.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
  typedef enum logic [1:0] {
    MODE_565  = 2'd0,
    MODE_555  = 2'd1,
    MODE_8X3  = 2'd2,
    MODE_QUAD = 2'd3
  } out_mode_e;

  localparam int CODE_W = 16;

  // bits one pixel adds to the stream
  function automatic int unsigned code_width(out_mode_e m);
    case (m)
      MODE_565: return 16;
      MODE_555: return 15;
      MODE_8X3: return 3;
      default:  return 4;
    endcase
  endfunction

  // bits one shift pulse removes
  function automatic int unsigned word_width(out_mode_e m);
    case (m)
      MODE_555: return 15;
      MODE_8X3: return 8;
      default:  return 16;
    endcase
  endfunction
endpackage

// File: rtl/pix_encode.sv
module pix_encode
  import pix_pack_pkg::*;
(
  input  out_mode_e         mode_i,
  input  logic [23:0]       pix_i,
  output logic [CODE_W-1:0] code_o
);
  logic [7:0] r, g, b;
  assign r = pix_i[23:16];
  assign g = pix_i[15:8];
  assign b = pix_i[7:0];

  logic unused_lsb;
  assign unused_lsb = ^{r[2:0], g[1:0], b[2:0]};

  always_comb begin
    code_o = '0;
    case (mode_i)
      MODE_565:  code_o = {r[7:3], g[7:2], b[7:3]};
      MODE_555:  code_o = {1'b0, r[7:3], g[7:3], b[7:3]};
      MODE_8X3:  code_o = {13'd0, r[7], g[7], b[7]};
      default:   code_o = {12'd0, r[6], r[7], g[7], b[7]};
    endcase
  end
endmodule

// File: rtl/pack_buffer.sv
module pack_buffer
  import pix_pack_pkg::*;
#(
  parameter int BUF_W  = 32,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  out_mode_e         mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              push_i,
  input  logic              shift_i,
  output logic              room_o,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int FILL_W = $clog2(BUF_W + 1);

  logic [BUF_W-1:0]  acc_q, acc_s, acc_d;
  logic [FILL_W-1:0] fill_q, fill_d, base, in_w, out_w;
  logic [DATA_W-1:0] mask, word_q;
  logic              take, vld_q;

  assign in_w  = FILL_W'(code_width(mode_i));
  assign out_w = FILL_W'(word_width(mode_i));
  assign room_o = ({1'b0, fill_q} + {1'b0, in_w}) <= (FILL_W + 1)'(BUF_W);
  assign take  = shift_i && (fill_q >= out_w);
  assign mask  = (DATA_W'(1) << out_w) - DATA_W'(1);

  always_comb begin
    acc_s  = take ? (acc_q >> out_w) : acc_q;
    base   = take ? (fill_q - out_w) : fill_q;
    acc_d  = acc_s;
    fill_d = base;
    if (push_i) begin
      acc_d  = acc_s | (BUF_W'(code_i) << base);
      fill_d = base + in_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      fill_q <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
      vld_q  <= take;
      if (shift_i) word_q <= take ? (acc_q[DATA_W-1:0] & mask) : '0;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_W'(BUF_W));
  a_r7_valid_needs_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(shift_i));
  a_r7_underrun_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && fill_q < out_w) |=> (!word_vld_o && word_o == '0));
  a_r10_mode_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q != '0) |-> $stable(mode_i));
  a_r6_555_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_555 && word_vld_o) |-> word_o[DATA_W-1:15] == '0);
endmodule

// File: rtl/pix_out_packer.sv
module pix_out_packer
  import pix_pack_pkg::*;
#(
  parameter int BUF_W  = 32,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [23:0]       pix_i,
  input  logic              pix_valid_i,
  output logic              pix_ready_o,
  input  logic              shift_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o
);
  out_mode_e         mode;
  logic [CODE_W-1:0] code;
  logic              room;

  assign mode = out_mode_e'(mode_i);

  pix_encode u_enc (
    .mode_i (mode),
    .pix_i  (pix_i),
    .code_o (code)
  );

  pack_buffer #(.BUF_W(BUF_W), .DATA_W(DATA_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .code_i     (code),
    .push_i     (pix_valid_i && room),
    .shift_i    (shift_en_i),
    .room_o     (room),
    .word_o     (data_o),
    .word_vld_o (data_valid_o)
  );

  assign pix_ready_o = room;

  a_r9_ready_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> pix_ready_o);
endmodule

// File: tb/tb_pix_out_packer.sv
`timescale 1ns/1ps
module tb_pix_out_packer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [23:0] pix_i = '0;
  logic        pix_valid_i = 1'b0;
  logic        pix_ready_o;
  logic        shift_en_i = 1'b0;
  logic [17:0] data_o;
  logic        data_valid_o;

  pix_out_packer dut (.*);

  always #10 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  int widx = 0;
  logic [23:0] q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_word(int m, int k);
    logic [17:0] w = '0;
    logic [23:0] p;
    case (m)
      0: begin p = q[k]; w[4:0] = p[7:3]; w[10:5] = p[15:10]; w[15:11] = p[23:19]; end
      1: begin p = q[k]; w[4:0] = p[7:3]; w[9:5] = p[15:11]; w[14:10] = p[23:19]; end
      2: for (int b = 0; b < 8; b++) begin
           int s = 8 * k + b;
           p = q[s / 3];
           w[b] = (s % 3 == 0) ? p[7] : (s % 3 == 1) ? p[15] : p[23];
         end
      default: for (int j = 0; j < 4; j++) begin
           p = q[4 * k + j];
           w[4*j] = p[7]; w[4*j+1] = p[15]; w[4*j+2] = p[23]; w[4*j+3] = p[22];
         end
    endcase
    return w;
  endfunction

  function automatic int pix_needed(int m, int k);
    case (m)
      0, 1: return k + 1;
      2: return (8 * k + 7) / 3 + 1;
      default: return 4 * k + 4;
    endcase
  endfunction

  string mtag[4] = '{"R1", "R2", "R3", "R5"};

  always @(posedge clk_i)
    if (rst_ni && pix_valid_i && pix_ready_o) q.push_back(pix_i);

  always @(negedge clk_i)
    if (rst_ni && data_valid_o) begin
      if (q.size() < pix_needed(int'(mode_i), widx))
        check("R7 word before enough pixels", 1, 0);
      else
        check({mtag[mode_i], " R6 word"}, 32'(data_o), 32'(exp_word(int'(mode_i), widx)));
      widx++;
    end

  task automatic do_reset(logic [1:0] m);
    @(negedge clk_i);
    rst_ni = 1'b0; pix_valid_i = 1'b0; shift_en_i = 1'b0; mode_i = m;
    q.delete(); widx = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 ready", 32'(pix_ready_o), 1);
    check("R9 valid", 32'(data_valid_o), 0);
    check("R9 data", 32'(data_o), 0);
  endtask

  task automatic push(logic [23:0] p);
    pix_valid_i = 1'b1; pix_i = p;
    while (!pix_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    pix_valid_i = 1'b0;
  endtask

  task automatic pulse_shift;
    shift_en_i = 1'b1;
    @(negedge clk_i);
    shift_en_i = 1'b0;
  endtask

  task automatic run_random(logic [1:0] m, int cycles);
    int start;
    do_reset(m);
    start = n_run;
    for (int c = 0; c < cycles; c++) begin
      pix_valid_i = ($urandom % 10) < 7;
      pix_i = 24'($urandom);
      shift_en_i = ($urandom % 2) == 1;
      @(negedge clk_i);
    end
    pix_valid_i = 1'b0;
    shift_en_i = 1'b1;
    repeat (8) @(negedge clk_i);
    shift_en_i = 1'b0;
    @(negedge clk_i);
    check({mtag[m], " words emitted"}, 32'(n_run - start > 10), 1);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));

    // R7: underrun gives empty word
    do_reset(2'd0);
    pulse_shift();
    check("R7 underrun valid", 32'(data_valid_o), 0);
    check("R7 underrun data", 32'(data_o), 0);
    check("R7 idle valid", 32'(data_valid_o), 0);

    // R1 directed + R8 full after two pixels
    do_reset(2'd0);
    push(24'hF8FCF8);
    push(24'h0800F0);
    check("R8 ready low at full 565", 32'(pix_ready_o), 0);
    pulse_shift();
    check("R1 565 all ones", 32'(data_o), 32'h0FFFF);
    check("R8 ready after shift", 32'(pix_ready_o), 1);
    pulse_shift();
    check("R1 565 mixed", 32'(data_o), 32'h0081E);

    // R2 directed
    do_reset(2'd1);
    push(24'hFFFFFF);
    pulse_shift();
    check("R2 R6 555 all ones", 32'(data_o), 32'h07FFF);

    // R4: split pixels in mode 2
    do_reset(2'd2);
    for (int i = 0; i < 8; i++)
      push(i == 2 ? 24'h800000 : i == 5 ? 24'h808000 : 24'h0);
    pulse_shift();
    check("R4 word0", 32'(data_o), 0);
    pulse_shift();
    check("R4 pixel2 red on P0", 32'(data_o), 32'h01);
    pulse_shift();
    check("R4 pixel5 G P0 R P1", 32'(data_o), 32'h03);

    // R8: ten pixels fill mode 2
    do_reset(2'd2);
    for (int i = 0; i < 10; i++) push(24'($urandom));
    check("R8 ready low after ten", 32'(pix_ready_o), 0);
    pulse_shift();
    check("R8 ready back", 32'(pix_ready_o), 1);

    // R5 directed
    do_reset(2'd3);
    push(24'h808080); push(24'h400000); push(24'h008000); push(24'h000080);
    pulse_shift();
    check("R5 quad word", 32'(data_o), 32'h1287);

    for (int m = 0; m < 4; m++) run_random(2'(m), 600);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule